// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block is the front end of a DMA read path. It takes one command at a time. In chained mode it reads a list of 8-byte descriptors from memory, starting at a base address. For every descriptor it issues one read request to a downstream data mover. The request carries a buffer address and a byte length. The walk ends after the descriptor whose end flag is set. In direct mode it skips memory and issues a single request built from the command's address and length fields.

The walker issues at most `MAX_DESC` descriptor reads per command. If none of them carries the end flag, it aborts and reports an error instead of completion. An optional accumulate mode adds the length of every accepted request to a running byte total, and that total survives across commands. A command flagged as final clears the total when it completes normally. Memory is a plain request/response port with one read outstanding at a time.

Top module: `dsc_chain_walker`

## Requirements
- R1: After reset the block is idle: `cmd_ready` is 1, `done`, `err`, `xfer_valid` and `mem_rd_req` are 0, and `byte_total` is 0.
- R2: A descriptor is one 64-bit read word. Bits [31:0] are the length word: bit 31 is the end flag and bits [30:0] are the byte length. Bits [63:32] are the buffer address. The request issued for a descriptor carries the buffer address ANDed with `BUF_ADDR_MASK` (default 0x7FFF_FFFF) and the 31-bit length, zero-extended to 32 bits. This holds for zero lengths as well.
- R3: In chained mode the first descriptor read uses `cmd_addr`, and each following read uses the previous address plus 8. Exactly one read is made per descriptor. No new read is issued before the previous response has arrived and the previous data request has been accepted.
- R4: A chained walk ends after the request of the first descriptor with the end flag set. `xfer_last` is 1 only on that request. `done` pulses for one cycle in the cycle after that request is accepted.
- R5: If `MAX_DESC` descriptors (default 256) have been read without an end flag, then once the last request is accepted `err` pulses for one cycle. No further descriptor is read.
- R6: In direct mode (`cmd_chain`=0) exactly one request is issued. It carries `cmd_addr` without masking and `cmd_len` unchanged, with `xfer_last`=1. No memory read takes place.
- R7: Each accepted command ends with exactly one pulse on either `done` or `err`, never both. `cmd_ready` returns to 1 in the following cycle.
- R8: `cmd_valid` is ignored while `cmd_ready` is 0. No request, read or outcome results from it.
- R9: When `cmd_accum` is 1, the length of every accepted request is added to `byte_total`. Commands with `cmd_accum`=0 leave `byte_total` unchanged.
- R10: An accumulate command with `cmd_final`=1 that ends with `done` leaves `byte_total` at 0. One that ends with `err` leaves the total, including the bytes it added, uncleared.
- R11: While `xfer_valid` is 1 and `xfer_ready` is 0, `xfer_valid`, `xfer_addr`, `xfer_len` and `xfer_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when `cmd_ready` is 1 |
| cmd_ready | output | 1 | Walker idle and able to take a command |
| cmd_chain | input | 1 | 1 walks a descriptor list, 0 issues a direct request |
| cmd_accum | input | 1 | Add requested bytes to the running total |
| cmd_final | input | 1 | Final request of an accumulated sequence |
| cmd_addr | input | 32 | List base address (chained) or buffer address (direct) |
| cmd_len | input | 32 | Byte length for direct mode |
| mem_rd_req | output | 1 | One-cycle descriptor read request |
| mem_rd_addr | output | 32 | Descriptor address |
| mem_rd_valid | input | 1 | Descriptor read response strobe |
| mem_rd_data | input | 64 | Descriptor word, offset 0 in bits [31:0] |
| xfer_valid | output | 1 | Data request valid |
| xfer_ready | input | 1 | Data mover accepts the request |
| xfer_addr | output | 32 | Buffer address of the request |
| xfer_len | output | 32 | Byte length of the request |
| xfer_last | output | 1 | Last request of this command |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle abort pulse for a missing end flag |
| byte_total | output | TOTAL_W | Running accumulated byte count |

## Verification
A wrong descriptor pointer shows at the data-mover port on the next request: that request comes from the wrong memory slot, so its address or length is wrong. A miscounted entry limit shows as an extra or missing request, or as a `done`/`err` swap, at the end of the longest lists. That is why the bench runs lists of exactly `MAX_DESC` entries, both with and without an end flag on the last one. Faults in the byte total appear on `byte_total` within two cycles of an outcome pulse. A clear that happens on the wrong event shows up as a nonzero or a zero value on the command that follows.

// File: rtl/sgw_pkg.sv
// Shared types for the descriptor walker.
// Assumes descriptors are 8 bytes and the length field is 31 bits wide.
package sgw_pkg;
    localparam int unsigned DESC_BYTES = 8;
    localparam int unsigned LEN_BITS   = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_ISSUE,
        ST_DONE,
        ST_FAIL
    } walk_state_t;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] len;
        logic        last;
    } xfer_t;
endpackage

// File: rtl/sgw_desc_unpack.sv
// Splits a raw 64-bit descriptor word into a request.
// The end flag is bit 31 and the length is bits [30:0]. The buffer
// address is the upper word, masked by BUF_ADDR_MASK.
// Purely combinational.
module sgw_desc_unpack
    import sgw_pkg::*;
#(
    parameter logic [31:0] BUF_ADDR_MASK = 32'h7FFF_FFFF
) (
    input  logic [63:0] raw,
    output xfer_t       req
);
    // Field extraction and address masking.
    always_comb begin
        req.last = raw[31];
        req.len  = {1'b0, raw[LEN_BITS-1:0]};
        req.addr = raw[63:32] & BUF_ADDR_MASK;
    end
endmodule

// File: rtl/sgw_entry_limit.sv
// Counts descriptors fetched within one command and flags when MAX_DESC
// is reached. Clear and increment are never asserted together.
module sgw_entry_limit #(
    parameter int unsigned MAX_DESC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int unsigned CW = $clog2(MAX_DESC + 1);

    logic [CW-1:0] cnt_q;

    // Per-command descriptor counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (inc)    cnt_q <= cnt_q + CW'(1);
    end

    // Limit reached once MAX_DESC entries have been read.
    assign at_limit = (cnt_q == CW'(MAX_DESC));
endmodule

// File: rtl/sgw_byte_tally.sv
// Running byte total carried across commands.
// Assumes add and clear are never asserted in the same cycle.
module sgw_byte_tally #(
    parameter int unsigned TOTAL_W = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               add_en,
    input  logic [31:0]        add_val,
    input  logic               clr_en,
    output logic [TOTAL_W-1:0] total
);
    // Accumulate on accepted requests, clear on a finished final command.
    always_ff @(posedge clk) begin
        if (!rst_n)       total <= '0;
        else if (clr_en)  total <= '0;
        else if (add_en)  total <= total + TOTAL_W'(add_val);
    end
endmodule

// File: rtl/dsc_chain_walker.sv
// Descriptor list walker. It takes one command at a time and issues data
// requests, either one per descriptor (chained) or a single one (direct).
// Assumes: the memory port returns exactly one response per read request;
// the data mover holds xfer_ready independent of xfer_valid.
module dsc_chain_walker
    import sgw_pkg::*;
#(
    parameter int unsigned TOTAL_W       = 40,
    parameter int unsigned MAX_DESC      = 256,
    parameter logic [31:0] BUF_ADDR_MASK = 32'h7FFF_FFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_chain,
    input  logic               cmd_accum,
    input  logic               cmd_final,
    input  logic [31:0]        cmd_addr,
    input  logic [31:0]        cmd_len,
    output logic               mem_rd_req,
    output logic [31:0]        mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [63:0]        mem_rd_data,
    output logic               xfer_valid,
    input  logic               xfer_ready,
    output logic [31:0]        xfer_addr,
    output logic [31:0]        xfer_len,
    output logic               xfer_last,
    output logic               done,
    output logic               err,
    output logic [TOTAL_W-1:0] byte_total
);
    walk_state_t state_q;
    logic [31:0] ptr_q;
    logic        accum_q;
    logic        final_q;
    xfer_t       req_q;
    xfer_t       desc_req;
    logic        accept;
    logic        fire;
    logic        at_limit;

    // Decode of the descriptor word currently on the response bus.
    sgw_desc_unpack #(.BUF_ADDR_MASK(BUF_ADDR_MASK)) u_unpack (
        .raw (mem_rd_data),
        .req (desc_req)
    );

    // Entries fetched in this command, against the hard limit.
    sgw_entry_limit #(.MAX_DESC(MAX_DESC)) u_limit (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .inc      (state_q == ST_WAIT && mem_rd_valid),
        .at_limit (at_limit)
    );

    // Byte total across accumulated commands.
    sgw_byte_tally #(.TOTAL_W(TOTAL_W)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (fire && accum_q),
        .add_val (req_q.len),
        .clr_en  (state_q == ST_DONE && accum_q && final_q),
        .total   (byte_total)
    );

    // Handshake terms.
    always_comb begin
        accept = cmd_valid && (state_q == ST_IDLE);
        fire   = (state_q == ST_ISSUE) && xfer_ready;
    end

    // Walk sequencer: fetch, wait for the response, issue, then decide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            accum_q <= 1'b0;
            final_q <= 1'b0;
            req_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        accum_q <= cmd_accum;
                        final_q <= cmd_final;
                        if (cmd_chain) begin
                            ptr_q   <= cmd_addr;
                            state_q <= ST_FETCH;
                        end else begin
                            req_q.addr <= cmd_addr;
                            req_q.len  <= cmd_len;
                            req_q.last <= 1'b1;
                            state_q    <= ST_ISSUE;
                        end
                    end
                end
                ST_FETCH: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rd_valid) begin
                        req_q   <= desc_req;
                        ptr_q   <= ptr_q + 32'(DESC_BYTES);
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (xfer_ready) begin
                        if (req_q.last)    state_q <= ST_DONE;
                        else if (at_limit) state_q <= ST_FAIL;
                        else               state_q <= ST_FETCH;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                ST_FAIL: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port views of the sequencer state.
    always_comb begin
        cmd_ready   = (state_q == ST_IDLE);
        mem_rd_req  = (state_q == ST_FETCH);
        mem_rd_addr = ptr_q;
        xfer_valid  = (state_q == ST_ISSUE);
        xfer_addr   = req_q.addr;
        xfer_len    = req_q.len;
        xfer_last   = req_q.last;
        done        = (state_q == ST_DONE);
        err         = (state_q == ST_FAIL);
    end
endmodule

// File: rtl/sgw_checker.sv
// Protocol checks for dsc_chain_walker, attached by bind.
// Watches only the ports and keeps its own read bookkeeping.
module sgw_checker #(
    parameter int unsigned MAX_DESC = 256
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        mem_rd_req,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rd_valid,
    input logic        xfer_valid,
    input logic        xfer_ready,
    input logic [31:0] xfer_addr,
    input logic [31:0] xfer_len,
    input logic        xfer_last,
    input logic        done,
    input logic        err
);
    localparam int unsigned CW = $clog2(MAX_DESC + 1);

    logic          outst_q;
    logic          seen_q;
    logic [31:0]   prev_q;
    logic [CW-1:0] rd_cnt_q;
    logic          acc_w;
    logic          hs_w;

    assign acc_w = cmd_valid && cmd_ready;
    assign hs_w  = xfer_valid && xfer_ready;

    // Track the outstanding read, the previous read address and reads per command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q  <= 1'b0;
            seen_q   <= 1'b0;
            prev_q   <= '0;
            rd_cnt_q <= '0;
        end else begin
            if (mem_rd_req)        outst_q <= 1'b1;
            else if (mem_rd_valid) outst_q <= 1'b0;
            if (acc_w) begin
                seen_q   <= 1'b0;
                rd_cnt_q <= '0;
            end else if (mem_rd_req) begin
                seen_q   <= 1'b1;
                prev_q   <= mem_rd_addr;
                rd_cnt_q <= rd_cnt_q + CW'(1);
            end
        end
    end

    assert_one_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !outst_q);
    assert_stride_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && seen_q) |-> (mem_rd_addr == prev_q + 32'd8));
    assert_end_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_w && xfer_last) |=> done);
    assert_read_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (rd_cnt_q < CW'(MAX_DESC)));
    assert_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_w && !xfer_last && rd_cnt_q == CW'(MAX_DESC)) |=> err);
    assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> cmd_ready);
    assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_w |=> !cmd_ready);
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr)
                                         && $stable(xfer_len) && $stable(xfer_last)));
endmodule

bind dsc_chain_walker sgw_checker #(.MAX_DESC(MAX_DESC)) u_chk (.*);

// File: tb/tb_dsc_chain_walker.sv
`timescale 1ns/1ps
module tb_dsc_chain_walker;
    localparam int unsigned MAXD = 256;
    localparam int unsigned TW   = 40;
    localparam logic [31:0] MASK = 32'h7FFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0, cmd_chain = 1'b0, cmd_accum = 1'b0, cmd_final = 1'b0;
    logic [31:0]   cmd_addr = '0, cmd_len = '0;
    logic          cmd_ready, mem_rd_req, mem_rd_valid = 1'b0;
    logic [31:0]   mem_rd_addr;
    logic [63:0]   mem_rd_data = '0;
    logic          xfer_valid, xfer_ready = 1'b0, xfer_last, done, err;
    logic [31:0]   xfer_addr, xfer_len;
    logic [TW-1:0] byte_total;

    always #2 clk = ~clk;

    dsc_chain_walker #(.TOTAL_W(TW), .MAX_DESC(MAXD), .BUF_ADDR_MASK(MASK)) dut (.*);

    typedef struct packed { logic [31:0] a; logic [31:0] l; logic last; } exp_t;
    exp_t          xq[$];
    bit            oq[$];
    logic [63:0]   dmem [0:1023];
    logic [TW-1:0] model_total = '0;
    int vectors = 0, fails = 0, rd_count = 0, outcomes = 0;
    logic [7:0] lf = 8'hA5;
    bit   pend = 0;
    int   dly = 0;
    logic [31:0] raddr = '0;

    task automatic note(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Memory responder: one response per read, variable latency.
    always @(negedge clk) begin
        if (mem_rd_valid) mem_rd_valid = 1'b0;
        if (pend) begin
            if (dly == 0) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = dmem[raddr[12:3]];
                pend = 0;
            end else dly--;
        end
        if (rst_n && mem_rd_req) begin
            pend = 1; dly = int'(lf[1:0]); raddr = mem_rd_addr; rd_count++;
        end
    end

    // Monitor: stalls the data mover and scores requests and outcomes.
    always @(negedge clk) begin
        if (rst_n) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            xfer_ready = lf[0] | lf[2];
            if (xfer_valid && xfer_ready) begin
                if (xq.size() == 0)
                    note(0, "R4", "unexpected request", {xfer_addr, xfer_len}, 64'h0);
                else begin
                    exp_t e;
                    e = xq.pop_front();
                    note(xfer_addr == e.a, "R2", "request address", 64'(xfer_addr), 64'(e.a));
                    note(xfer_len == e.l, "R2", "request length", 64'(xfer_len), 64'(e.l));
                    note(xfer_last == e.last, "R4", "last flag", 64'(xfer_last), 64'(e.last));
                end
            end
            if (done || err) begin
                outcomes++;
                if (oq.size() == 0)
                    note(0, "R7", "unexpected outcome", {62'h0, err, done}, 64'h0);
                else begin
                    bit eo;
                    eo = oq.pop_front();
                    note(done == !eo && err == eo, eo ? "R5" : "R4", "outcome pulse",
                         {62'h0, err, done}, {62'h0, eo, !eo});
                end
            end
        end
    end

    // Independent walk of the bench memory to form expectations.
    task automatic expect_chain(input logic [31:0] base, input bit accum, input bit fin,
                                output int nent);
        logic [31:0] p;
        logic [63:0] w;
        logic [TW-1:0] sum;
        bit ended;
        p = base; sum = '0; ended = 0; nent = 0;
        for (int i = 0; i < int'(MAXD); i++) begin
            w = dmem[p[12:3]];
            xq.push_back({w[63:32] & MASK, {1'b0, w[30:0]}, w[31]});
            sum += TW'(w[30:0]);
            nent++;
            p += 32'd8;
            if (w[31]) begin ended = 1; break; end
        end
        oq.push_back(!ended);
        if (accum) model_total += sum;
        if (accum && fin && ended) model_total = '0;
    endtask

    task automatic run_cmd(input bit chain, input bit accum, input bit fin,
                           input logic [31:0] addr, input logic [31:0] len,
                           input bit poke, input string tag);
        int n, rd0, oc0;
        n = 0; rd0 = rd_count; oc0 = outcomes;
        if (chain) expect_chain(addr, accum, fin, n);
        else begin
            xq.push_back({addr, len, 1'b1});
            oq.push_back(1'b0);
            if (accum) model_total += TW'(len);
            if (accum && fin) model_total = '0;
        end
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_chain = chain; cmd_accum = accum; cmd_final = fin;
        cmd_addr = addr; cmd_len = len;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (poke) begin
            // R8: a second command while busy must leave no trace.
            repeat (2) @(negedge clk);
            cmd_valid = 1'b1; cmd_chain = 1'b0; cmd_accum = 1'b1; cmd_final = 1'b1;
            cmd_addr = 32'h0BAD_0000; cmd_len = 32'h77;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (outcomes == oc0) @(negedge clk);
        repeat (3) @(negedge clk);
        note(rd_count - rd0 == n, chain ? "R3" : "R6", {tag, " descriptor reads"},
             64'(rd_count - rd0), 64'(n));
        note(byte_total == model_total, accum ? "R10" : "R9", {tag, " byte total"},
             64'(byte_total), 64'(model_total));
        note(cmd_ready == 1'b1, "R7", {tag, " ready after outcome"}, 64'(cmd_ready), 64'h1);
        if (poke)
            note(xq.size() == 0 && oq.size() == 0, "R8", "busy command ignored",
                 64'(xq.size() + oq.size()), 64'h0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        vectors++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Stimulus.
    initial begin
        for (int i = 0; i < 1024; i++) dmem[i] = '0;
        for (int i = 0; i < 256; i++)
            dmem[i] = {(32'(i) * 32'h40) | (i[0] ? 32'h8000_0000 : 32'h0), 1'b0, 31'(i % 7 + 1)};
        dmem[256] = {32'h0000_5000, 1'b1, 31'h20};
        dmem[512] = {32'h8000_2000, 1'b0, 31'h10};
        dmem[513] = {32'h0000_3004, 1'b0, 31'h7FFF_FFF0};
        dmem[514] = {32'hFFFF_FFFF, 1'b1, 31'h30};
        dmem[544] = {32'h0000_4000, 1'b0, 31'h100};
        dmem[545] = {32'h0000_4400, 1'b1, 31'h80};
        dmem[576] = {32'h0000_6000, 1'b1, 31'h0};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        note(cmd_ready == 1'b1, "R1", "ready", 64'(cmd_ready), 64'h1);
        note(!done && !err && !xfer_valid && !mem_rd_req, "R1", "quiet outputs",
             {60'h0, done, err, xfer_valid, mem_rd_req}, 64'h0);
        note(byte_total == '0, "R1", "total", 64'(byte_total), 64'h0);

        run_cmd(0, 0, 0, 32'h8000_1234, 32'h100, 0, "R6 direct");
        run_cmd(1, 0, 0, 32'h0000_1000, 32'h0, 0, "R2 chain mask");
        run_cmd(1, 0, 0, 32'h0000_1200, 32'h0, 0, "R4 single zero-length");
        run_cmd(1, 1, 0, 32'h0000_1100, 32'h0, 0, "R9 accum chain");
        run_cmd(0, 0, 0, 32'h0000_7000, 32'h55, 0, "R9 plain after accum");
        run_cmd(0, 1, 0, 32'h0000_7100, 32'h20, 0, "R9 accum direct");
        run_cmd(0, 1, 1, 32'h0000_7200, 32'h40, 0, "R10 final clears");
        run_cmd(1, 1, 1, 32'h0000_0000, 32'h0, 0, "R5 limit abort");
        run_cmd(0, 1, 1, 32'h0000_7300, 32'h4, 0, "R10 clear after abort");
        run_cmd(1, 0, 0, 32'h0000_0008, 32'h0, 0, "R5 full list with end");
        run_cmd(1, 0, 0, 32'h0000_1000, 32'h0, 1, "R8 busy poke");

        note(xq.size() == 0 && oq.size() == 0, "R4", "leftover expectations",
             64'(xq.size() + oq.size()), 64'h0);
        finish_run();
    end
endmodule